// File: doc/BRIEF.md
# UART Automatic Flow Control

This block makes the RTS/CTS handshake decisions for a UART. On the receive side it compares the receive-buffer fill count with one of four selectable fill thresholds. It drives the active-low RTS pin with hysteresis. The pin goes high (stop sending) once the count reaches the selected threshold. It goes low again only after the count has drained down to the next-lower threshold. A byte read that moves the count back by one does not release it.

On the transmit side, a two-stage synchronizer samples the active-low CTS pin. While automatic CTS is on, the synchronized value gates the permit that lets the transmitter begin its next character. A character that is already being shifted out is never cut short, because only the start permit is withheld.

When automatic RTS is off, a software request bit drives the pin. A status output always reports whether the pin is asserted, so in automatic mode it shows what the hardware chose. The receive storage and the serial shifters are outside this block. Because RTS rises only when the buffer reaches the threshold, the buffer must keep room for at least one more byte above the highest threshold. That byte covers a far end that was already sending when RTS rose.

Top module: `uart_flowctl`

## Requirements
- R1: Trigger select values 0, 1, 2 and 3 choose an upper threshold of 1, 4, 8 and 14 bytes. The matching lower threshold is 0, 1, 4 and 8 bytes, which is the previous select's upper threshold, or 0 for select 0.
- R2: With automatic RTS on, `rts_n` is 1 in every cycle where `rx_level` is at or above the upper threshold, and it stays 1 for a count one above the highest threshold.
- R3: With automatic RTS on, once `rts_n` is 1 it stays 1 while `rx_level` is strictly between the two thresholds. It returns to 0 only when `rx_level` is at or below the lower threshold, and then stays 0 between the thresholds until the upper threshold is reached again.
- R4: During reset, and in the first cycle after automatic RTS is switched on, `rts_n` is 0 when `rx_level` is below the upper threshold and 1 otherwise.
- R5: With automatic RTS off, `rts_n` equals the inverse of `sw_rts`, so `sw_rts` = 1 drives the pin low, whatever `rx_level` is.
- R6: With automatic RTS on, `sw_rts` has no effect on `rts_n`.
- R7: `rts_stat` is 1 exactly when `rts_n` is 0, in both modes.
- R8: With automatic CTS on, `tx_start` is 1 only when `tx_ready` is 1 and `cts_n` was 0 two rising clock edges earlier. A change on `cts_n` reaches `tx_start` after two rising edges.
- R9: With automatic CTS off, `tx_start` equals `tx_ready`.
- R10: Reset loads the CTS synchronizer with the deasserted (high) value. After reset, `tx_start` stays 0 under automatic CTS until `cts_n` has been low for two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 5 | Current receive-buffer fill count (0..DEPTH) |
| trig_sel | input | 2 | Threshold select |
| auto_rts_en | input | 1 | Automatic RTS enable |
| auto_cts_en | input | 1 | Automatic CTS enable |
| sw_rts | input | 1 | Software RTS request, 1 = assert |
| cts_n | input | 1 | CTS pin, active low, asynchronous |
| tx_ready | input | 1 | Transmitter has a character and is at a character boundary |
| rts_n | output | 1 | RTS pin, active low |
| tx_start | output | 1 | Permit to begin the next character |
| rts_stat | output | 1 | 1 when the RTS pin is asserted (low) |

## Verification
The receive side is tried with count sequences that climb through the upper threshold, wander inside the band between the thresholds in both directions, and drain to the lower threshold. This shows the difference between true hysteresis and a single compare or release-on-first-read. The same walk is repeated for every threshold select, including the empty-buffer release of select 0 and a count one past the highest threshold. Mode switches separate hardware control from the software request, and one switch into automatic mode with the count inside the band checks the initial choice. CTS edges are counted against the two-stage delay in both directions, and with gating off, so a wrong synchronizer depth or a wrong reset value shows up.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

  // Receive-buffer depth; must exceed the highest threshold by at least one.
  localparam int unsigned DEPTH   = 16;
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1);
  localparam int unsigned NUM_TRIG = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_TRIG);

  typedef logic [LVL_W-1:0] level_t;

  typedef struct packed {
    level_t hi;
    level_t lo;
  } thresh_t;

endpackage

// File: rtl/flowctl_thresh.sv
module flowctl_thresh
  import flowctl_pkg::*;
#(
  parameter int unsigned T0 = 1,
  parameter int unsigned T1 = 4,
  parameter int unsigned T2 = 8,
  parameter int unsigned T3 = 14
) (
  input  logic [SEL_W-1:0] sel,
  output thresh_t          th
);

  localparam level_t L0 = level_t'(T0);
  localparam level_t L1 = level_t'(T1);
  localparam level_t L2 = level_t'(T2);
  localparam level_t L3 = level_t'(T3);

  always_comb begin
    unique case (sel)
      2'd0:    th = '{hi: L0, lo: '0};
      2'd1:    th = '{hi: L1, lo: L0};
      2'd2:    th = '{hi: L2, lo: L1};
      default: th = '{hi: L3, lo: L2};
    endcase
  end

  // R1: thresholds strictly ordered and the top one leaves one spare slot
  always_comb begin
    threshold_order_chk: assert (th.hi > th.lo && th.hi < level_t'(DEPTH));
  end

endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts
  import flowctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  level_t  level,
  input  thresh_t th,
  input  logic    auto_en,
  input  logic    sw_req,
  output logic    rts_n
);

  logic at_hi, at_lo;
  logic hyst_off;
  logic held_q, held_d;
  logic armed_q, armed_d;

  always_comb begin
    at_hi = (level >= th.hi);
    at_lo = (level <= th.lo);
    if (at_hi)        hyst_off = 1'b1;
    else if (at_lo)   hyst_off = 1'b0;
    else if (armed_q) hyst_off = held_q;
    else              hyst_off = 1'b0;
  end

  always_comb begin
    held_d  = hyst_off;
    armed_d = auto_en;
    rts_n   = auto_en ? hyst_off : ~sw_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      held_q  <= held_d;
      armed_q <= armed_d;
    end
  end

  // R2
  rts_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && at_hi |-> rts_n);

  // R3
  rts_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && $past(auto_en) && $stable(th) && !at_hi && !at_lo
      |-> rts_n == $past(rts_n));

  // R4
  rts_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && !$past(auto_en) && !at_hi |-> !rts_n);

  // R5
  rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> rts_n == !sw_req);

endmodule

// File: rtl/flowctl_cts.sv
module flowctl_cts
  import flowctl_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_en,
  input  logic tx_ready,
  output logic tx_start
);

  logic [STAGES-1:0] sync_q, sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = cts_n;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], cts_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  always_comb tx_start = tx_ready & (~auto_en | ~sync_q[STAGES-1]);

  // R8
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && $past(cts_n, 2) |-> !tx_start);

  // R9
  cts_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> tx_start == tx_ready);

  // R8
  tx_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_ready);

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
  import flowctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             sw_rts,
  input  logic             cts_n,
  input  logic             tx_ready,
  output logic             rts_n,
  output logic             tx_start,
  output logic             rts_stat
);

  thresh_t th;
  logic    rts_pin_n;

  flowctl_thresh #(.T0(1), .T1(4), .T2(8), .T3(14)) u_thresh (
    .sel (trig_sel),
    .th  (th)
  );

  flowctl_rts u_rts (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (rx_level),
    .th      (th),
    .auto_en (auto_rts_en),
    .sw_req  (sw_rts),
    .rts_n   (rts_pin_n)
  );

  flowctl_cts #(.STAGES(2)) u_cts (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_n    (cts_n),
    .auto_en  (auto_cts_en),
    .tx_ready (tx_ready),
    .tx_start (tx_start)
  );

  always_comb begin
    rts_n    = rts_pin_n;
    rts_stat = ~rts_pin_n;
  end

  // R1: the fill count never exceeds the buffer depth
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= level_t'(DEPTH));

endmodule

// File: tb/test_uart_flowctl.sv
module test_uart_flowctl;
  import flowctl_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LVL_W-1:0] rx_level;
  logic [SEL_W-1:0] trig_sel;
  logic             auto_rts_en, auto_cts_en, sw_rts, cts_n, tx_ready;
  logic             rts_n, tx_start, rts_stat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  uart_flowctl i_uart_flowctl (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .sw_rts(sw_rts),
    .cts_n(cts_n), .tx_ready(tx_ready), .rts_n(rts_n), .tx_start(tx_start),
    .rts_stat(rts_stat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic       auto;
    logic [1:0] sel;
    logic [4:0] lvl;
    logic       sw;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 5'd0,  1'b0, 1'b0, 4'd3},  // R3 below band
    '{1'b1, 2'd2, 5'd5,  1'b0, 1'b0, 4'd3},  // R3 rising in band
    '{1'b1, 2'd2, 5'd7,  1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd2, 5'd8,  1'b0, 1'b1, 4'd2},  // R2 reach threshold
    '{1'b1, 2'd2, 5'd9,  1'b0, 1'b1, 4'd2},
    '{1'b1, 2'd2, 5'd7,  1'b1, 1'b1, 4'd6},  // R6 software request ignored
    '{1'b1, 2'd2, 5'd5,  1'b0, 1'b1, 4'd3},  // R3 falling in band holds
    '{1'b1, 2'd2, 5'd4,  1'b0, 1'b0, 4'd3},  // R3 release at lower
    '{1'b1, 2'd2, 5'd5,  1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd2, 5'd8,  1'b0, 1'b1, 4'd2},
    '{1'b1, 2'd2, 5'd4,  1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 4'd1},  // R1 select 0
    '{1'b1, 2'd0, 5'd1,  1'b0, 1'b1, 4'd1},
    '{1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 4'd1},
    '{1'b1, 2'd3, 5'd10, 1'b0, 1'b0, 4'd1},  // R1 select 3
    '{1'b1, 2'd3, 5'd14, 1'b0, 1'b1, 4'd1},
    '{1'b1, 2'd3, 5'd15, 1'b0, 1'b1, 4'd2},  // R2 spare byte
    '{1'b1, 2'd3, 5'd9,  1'b0, 1'b1, 4'd3},
    '{1'b1, 2'd3, 5'd8,  1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd1, 5'd3,  1'b0, 1'b0, 4'd1},  // R1 select 1
    '{1'b1, 2'd1, 5'd4,  1'b0, 1'b1, 4'd1},
    '{1'b1, 2'd1, 5'd2,  1'b0, 1'b1, 4'd3},
    '{1'b1, 2'd1, 5'd1,  1'b0, 1'b0, 4'd3},
    '{1'b0, 2'd2, 5'd12, 1'b1, 1'b0, 4'd5},  // R5 manual
    '{1'b0, 2'd2, 5'd12, 1'b0, 1'b1, 4'd5},
    '{1'b0, 2'd2, 5'd0,  1'b0, 1'b1, 4'd5},
    '{1'b0, 2'd2, 5'd6,  1'b1, 1'b0, 4'd5},
    '{1'b1, 2'd2, 5'd6,  1'b0, 1'b0, 4'd4},  // R4 just enabled in band
    '{1'b1, 2'd2, 5'd7,  1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd2, 5'd9,  1'b0, 1'b1, 4'd2}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_level = 5'd10; trig_sel = 2'd2;
    auto_rts_en = 1'b1; auto_cts_en = 1'b1; sw_rts = 1'b0;
    cts_n = 1'b0; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R4: reset, count above threshold
    check("R4 reset at-threshold rts_n", rts_n, 1'b1);
    // R10: synchronizer holds deasserted during reset
    check("R10 reset tx_start", tx_start, 1'b0);
    rx_level = 5'd5; #1;
    // R4: reset, count inside band
    check("R4 reset in-band rts_n", rts_n, 1'b0);
    // R7
    check("R7 reset rts_stat", rts_stat, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    rx_level = 5'd0;

    // Table walk: drive at negedge, sample 1 time unit later
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      auto_rts_en = VEC[i].auto; trig_sel = VEC[i].sel;
      rx_level = VEC[i].lvl; sw_rts = VEC[i].sw;
      #1;
      check($sformatf("R%0d vec%0d rts_n", VEC[i].req, i), rts_n, VEC[i].exp);
      // R7
      check($sformatf("R7 vec%0d rts_stat", i), rts_stat, ~VEC[i].exp);
    end

    // R10: cts_n was low since reset; two edges after release permit opens
    // R8: raise cts_n, permit closes after two edges
    @(negedge clk);
    auto_cts_en = 1'b1; tx_ready = 1'b1; cts_n = 1'b1;
    #1;
    check("R8 cts high edge0", tx_start, 1'b1);
    @(negedge clk); #1;
    check("R8 cts high edge1", tx_start, 1'b1);
    @(negedge clk); #1;
    check("R8 cts high edge2", tx_start, 1'b0);
    cts_n = 1'b0;
    @(negedge clk); #1;
    check("R8 cts low edge1", tx_start, 1'b0);
    @(negedge clk); #1;
    check("R8 cts low edge2", tx_start, 1'b1);
    tx_ready = 1'b0; #1;
    check("R8 not ready", tx_start, 1'b0);

    // R9: gating off passes tx_ready despite high CTS
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    auto_cts_en = 1'b0; tx_ready = 1'b1; #1;
    check("R9 bypass ready", tx_start, 1'b1);
    tx_ready = 1'b0; #1;
    check("R9 bypass idle", tx_start, 1'b0);

    // R10: fresh reset with CTS already low
    @(negedge clk);
    rst_n = 1'b0; auto_cts_en = 1'b1; tx_ready = 1'b1; cts_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    check("R10 after reset edge0", tx_start, 1'b0);
    @(negedge clk); #1;
    check("R10 after reset edge1", tx_start, 1'b0);
    @(negedge clk); #1;
    check("R10 after reset edge2", tx_start, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule